// File: doc/BRIEF.md
# Indirect Access Register Window

This block is the slave side of a small memory-mapped window through which a host reaches a table of per-channel 8-bit settings without mapping each one. The host picks a channel and a setting offset through two selector registers. It then places a value in a data register and sets a command bit in the control word. The block runs the access to the internal table over a fixed number of cycles and shows a busy flag in the control word while the access is in flight.

Offset 0 selects the output-swing setting and offset 1 selects the pre-emphasis pre-tap setting; the remaining offsets up to the parameterised count are further slots. A write command copies the data register into the selected slot when the access ends. A read command loads the selected slot into the data register when the access ends. A command that arrives while busy, or that names a channel or offset outside the table, is dropped and raises a sticky error flag.

Top module: `ind_reg_window`

## Requirements
- R1: After reset the channel, offset and data registers, the control word, read data and every table slot read back as zero.
- R2: Word address 0x8 holds the channel selector and 0xB the offset selector, each keeping the low 8 bits written. 0xC holds the data register, keeping the low 8 bits. 0xA is the control word. Every other address reads as 0 and ignores writes. Read data appears on `rdata` the cycle after `rd_en` and holds until the next read.
- R3: Writing 1 to control bit 0 starts a write access, after which the slot chosen by channel and offset holds the data register value.
- R4: Writing 1 to control bit 1 starts a read access. The data register takes the slot value at the end of the access and keeps its earlier value until then.
- R5: Control bit 8 (busy) reads 1 in exactly BUSY_CYC consecutive cycles after the edge that accepts a command, then 0.
- R6: Control bits 0 and 1 always read back as 0.
- R7: A command written while busy is ignored and sets control bit 9 (error). The access in flight still completes as started.
- R8: A command whose channel is at or above NUM_CH, or whose offset is at or above NUM_OFS, sets the error bit, does not raise busy and changes neither the table nor the data register.
- R9: The error bit stays set until a control write with bit 9 equal to 1. If the same write also carries a rejected command, the error bit stays set.
- R10: A control write with both bits 0 and 1 set performs a write access.
- R11: An access uses the channel, offset and data values present when it was accepted. Register writes during busy take effect in those registers but do not redirect the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one word |
| rd_en | input | 1 | Read strobe for one word |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |

## Verification
A counter in the access sequencer stuck or mis-loaded shows up as a busy flag of the wrong length in the control word. It is visible within BUSY_CYC+1 status reads after a command. Captured selectors or a wrong table index do not show up until a later read access returns a value from the wrong slot. The bench therefore reads back both the slot it wrote and slots it must not have touched. A stale or mis-set error flag appears at the next status read, and a data register loaded at the wrong time is caught by reading it while busy is still high.

// File: rtl/iw_pkg.sv
package iw_pkg;

  localparam int unsigned ADR_CHAN = 8;
  localparam int unsigned ADR_CTRL = 10;
  localparam int unsigned ADR_OFS  = 11;
  localparam int unsigned ADR_DATA = 12;

  localparam int unsigned BIT_DO_WR = 0;
  localparam int unsigned BIT_DO_RD = 1;
  localparam int unsigned BIT_BUSY  = 8;
  localparam int unsigned BIT_ERR   = 9;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_CHAN,
    TGT_CTRL,
    TGT_OFS,
    TGT_DATA
  } tgt_e;

  // linear slot number inside the settings table
  function automatic int flat_idx(input int ch, input int ofs, input int n_ofs);
    return ch * n_ofs + ofs;
  endfunction

  // true when the selectors point inside the table
  function automatic logic sel_ok(input int ch, input int ofs, input int n_ch, input int n_ofs);
    return (ch < n_ch) && (ofs < n_ofs);
  endfunction

endpackage

// File: rtl/iw_decode.sv
module iw_decode #(
  parameter int ADDR_W = 4
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output iw_pkg::tgt_e      tgt,
  output logic              wr_chan,
  output logic              wr_ofs,
  output logic              wr_data,
  output logic              wr_ctrl,
  output logic              rd_ctrl
);
  import iw_pkg::*;

  always_comb begin
    if (addr == ADDR_W'(ADR_CHAN))      tgt = TGT_CHAN;
    else if (addr == ADDR_W'(ADR_CTRL)) tgt = TGT_CTRL;
    else if (addr == ADDR_W'(ADR_OFS))  tgt = TGT_OFS;
    else if (addr == ADDR_W'(ADR_DATA)) tgt = TGT_DATA;
    else                                tgt = TGT_NONE;
  end

  assign wr_chan = wr_en && (tgt == TGT_CHAN);
  assign wr_ofs  = wr_en && (tgt == TGT_OFS);
  assign wr_data = wr_en && (tgt == TGT_DATA);
  assign wr_ctrl = wr_en && (tgt == TGT_CTRL);
  assign rd_ctrl = rd_en && (tgt == TGT_CTRL);

endmodule

// File: rtl/iw_seq.sv
module iw_seq #(
  parameter int BUSY_CYC = 4,
  parameter int REG_W    = 8,
  parameter int SET_W    = 8,
  parameter int NUM_CH   = 4,
  parameter int NUM_OFS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             req_wr,
  input  logic             req_rd,
  input  logic             err_clr,
  input  logic [REG_W-1:0] sel_chan,
  input  logic [REG_W-1:0] sel_ofs,
  input  logic [SET_W-1:0] sel_data,
  output logic             busy,
  output logic             err,
  output logic             cmd_req,
  output logic             cmd_rej,
  output logic             cmd_bad,
  output logic             cmd_accept,
  output logic             acc_done,
  output logic             acc_is_wr,
  output logic [REG_W-1:0] acc_chan,
  output logic [REG_W-1:0] acc_ofs,
  output logic [SET_W-1:0] acc_data
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sel_fits;

  assign busy     = (cnt_q != '0);
  assign acc_done = (cnt_q == CNT_W'(1));

  assign sel_fits   = iw_pkg::sel_ok(int'(sel_chan), int'(sel_ofs), NUM_CH, NUM_OFS);
  assign cmd_req    = wr_ctrl && (req_wr || req_rd);
  assign cmd_rej    = cmd_req && busy;
  assign cmd_bad    = cmd_req && !busy && !sel_fits;
  assign cmd_accept = cmd_req && !busy && sel_fits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      acc_is_wr <= 1'b0;
      acc_chan  <= '0;
      acc_ofs   <= '0;
      acc_data  <= '0;
    end else if (cmd_accept) begin
      cnt_q     <= CNT_W'(BUSY_CYC);
      acc_is_wr <= req_wr;
      acc_chan  <= sel_chan;
      acc_ofs   <= sel_ofs;
      acc_data  <= sel_data;
    end else if (busy) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // a new fault wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  err <= 1'b0;
    else if (cmd_rej || cmd_bad) err <= 1'b1;
    else if (wr_ctrl && err_clr) err <= 1'b0;
  end

endmodule

// File: rtl/iw_store.sv
module iw_store #(
  parameter int NUM_CH  = 4,
  parameter int NUM_OFS = 4,
  parameter int SET_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [SET_W-1:0] wval,
  output logic [SET_W-1:0] rval
);
  localparam int DEPTH = NUM_CH * NUM_OFS;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SET_W-1:0] ent [DEPTH];
  logic [DEPTH-1:0] hit;

  for (genvar e = 0; e < DEPTH; e++) begin : g_hit
    assign hit[e] = we && (idx == IDX_W'(e));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) ent[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (hit[e]) ent[e] <= wval;
      end
    end
  end

  assign rval = (int'(idx) < DEPTH) ? ent[idx] : '0;

endmodule

// File: rtl/ind_reg_window.sv
module ind_reg_window #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int REG_W    = 8,
  parameter int SET_W    = 8,
  parameter int NUM_CH   = 4,
  parameter int NUM_OFS  = 4,
  parameter int BUSY_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  import iw_pkg::*;

  localparam int DEPTH = NUM_CH * NUM_OFS;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  tgt_e tgt;
  logic wr_chan, wr_ofs, wr_data, wr_ctrl, rd_ctrl;

  iw_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .tgt    (tgt),
    .wr_chan(wr_chan),
    .wr_ofs (wr_ofs),
    .wr_data(wr_data),
    .wr_ctrl(wr_ctrl),
    .rd_ctrl(rd_ctrl)
  );

  logic [REG_W-1:0] chan_q, ofs_q;
  logic [SET_W-1:0] data_q;

  logic             busy, err;
  logic             cmd_req, cmd_rej, cmd_bad, cmd_accept;
  logic             acc_done, acc_is_wr;
  logic [REG_W-1:0] acc_chan, acc_ofs;
  logic [SET_W-1:0] acc_data;
  logic             err_clr_wr;
  logic             load_data;

  iw_seq #(
    .BUSY_CYC(BUSY_CYC),
    .REG_W   (REG_W),
    .SET_W   (SET_W),
    .NUM_CH  (NUM_CH),
    .NUM_OFS (NUM_OFS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_ctrl),
    .req_wr    (wdata[BIT_DO_WR]),
    .req_rd    (wdata[BIT_DO_RD]),
    .err_clr   (wdata[BIT_ERR]),
    .sel_chan  (chan_q),
    .sel_ofs   (ofs_q),
    .sel_data  (data_q),
    .busy      (busy),
    .err       (err),
    .cmd_req   (cmd_req),
    .cmd_rej   (cmd_rej),
    .cmd_bad   (cmd_bad),
    .cmd_accept(cmd_accept),
    .acc_done  (acc_done),
    .acc_is_wr (acc_is_wr),
    .acc_chan  (acc_chan),
    .acc_ofs   (acc_ofs),
    .acc_data  (acc_data)
  );

  assign err_clr_wr = wr_ctrl && wdata[BIT_ERR];
  assign load_data  = acc_done && !acc_is_wr;

  logic [IDX_W-1:0] store_idx;
  logic [SET_W-1:0] store_rd;

  assign store_idx = IDX_W'(flat_idx(int'(acc_chan), int'(acc_ofs), NUM_OFS));

  iw_store #(
    .NUM_CH (NUM_CH),
    .NUM_OFS(NUM_OFS),
    .SET_W  (SET_W)
  ) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (acc_done && acc_is_wr),
    .idx  (store_idx),
    .wval (acc_data),
    .rval (store_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      ofs_q  <= '0;
    end else begin
      if (wr_chan) chan_q <= wdata[REG_W-1:0];
      if (wr_ofs)  ofs_q  <= wdata[REG_W-1:0];
    end
  end

  // a completing read access takes priority over a host write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data_q <= '0;
    else if (load_data) data_q <= store_rd;
    else if (wr_data)   data_q <= wdata[SET_W-1:0];
  end

  logic [DATA_W-1:0] status_w, rd_word;

  always_comb begin
    status_w           = '0;
    status_w[BIT_BUSY] = busy;
    status_w[BIT_ERR]  = err;
  end

  always_comb begin
    case (tgt)
      TGT_CHAN: rd_word = DATA_W'(chan_q);
      TGT_OFS:  rd_word = DATA_W'(ofs_q);
      TGT_DATA: rd_word = DATA_W'(data_q);
      TGT_CTRL: rd_word = status_w;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata;

endmodule

// File: rtl/iw_checker.sv
module iw_checker #(
  parameter int BUSY_CYC = 4,
  parameter int DATA_W   = 32,
  parameter int SET_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              err,
  input logic              cmd_accept,
  input logic              cmd_rej,
  input logic              cmd_bad,
  input logic              acc_done,
  input logic              load_data,
  input logic              wr_data,
  input logic              err_clr_wr,
  input logic              rd_ctrl,
  input logic [DATA_W-1:0] rdata,
  input logic [SET_W-1:0]  data_q
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  p_busy_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < BUSY_CYC));

  p_accept_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> busy);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !busy);

  p_busy_shown_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |=> (rdata[8] == $past(busy)));

  p_cmd_bits_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |=> (rdata[1:0] == 2'b00));

  p_reject_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rej |=> err);

  p_bad_no_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bad |=> (err && !busy));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr_wr) |=> err);

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_data && !wr_data) |=> $stable(data_q));

endmodule

bind ind_reg_window iw_checker #(
  .BUSY_CYC(BUSY_CYC),
  .DATA_W  (DATA_W),
  .SET_W   (SET_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .err       (err),
  .cmd_accept(cmd_accept),
  .cmd_rej   (cmd_rej),
  .cmd_bad   (cmd_bad),
  .acc_done  (acc_done),
  .load_data (load_data),
  .wr_data   (wr_data),
  .err_clr_wr(err_clr_wr),
  .rd_ctrl   (rd_ctrl),
  .rdata     (rdata),
  .data_q    (data_q)
);

// File: tb/sim_ind_reg_window.sv
module sim_ind_reg_window;
  localparam int BUSY = 4;
  localparam logic [3:0] A_CH = 4'h8, A_CTRL = 4'hA, A_OFS = 4'hB, A_DATA = 4'hC;
  localparam logic [31:0] ST_BUSY = 32'h100, ST_ERR = 32'h200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  logic rd_took = 1'b0;

  always #5 clk = ~clk;

  ind_reg_window u0 (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_en),
    .rd_en(rd_en),
    .addr (addr),
    .wdata(wdata),
    .rdata(rdata)
  );

  always @(posedge clk) rd_took <= rd_en;

  // monitor: compares the word captured at the last edge with the queue head
  always @(negedge clk) begin
    if (rd_took) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_err++;
        $display("FAIL scoreboard empty: actual=%h expected=none", rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (rdata !== it.exp) begin
          n_err++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; addr = a; wdata = '0;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
    end
  endtask

  task automatic fetch(input int ch, input int ofs, input logic [7:0] e, input string tag);
    wr(A_CH, 32'(ch));
    wr(A_OFS, 32'(ofs));
    wr(A_CTRL, 32'h2);
    idle(BUSY);
    rd(A_DATA, 32'(e), tag);
  endtask

  task automatic store(input int ch, input int ofs, input logic [7:0] v);
    wr(A_CH, 32'(ch));
    wr(A_OFS, 32'(ofs));
    wr(A_DATA, 32'(v));
    wr(A_CTRL, 32'h1);
    idle(BUSY);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CH,   32'h0, "R1 channel after reset");
    rd(A_OFS,  32'h0, "R1 offset after reset");
    rd(A_DATA, 32'h0, "R1 data after reset");
    rd(A_CTRL, 32'h0, "R1 control after reset");
    fetch(3, 3, 8'h00, "R1 table slot after reset");

    // R2 decode and field widths
    wr(A_CH, 32'h1F5);
    rd(A_CH, 32'hF5, "R2 channel keeps low byte");
    wr(A_DATA, 32'h1AB);
    rd(A_DATA, 32'hAB, "R2 data keeps low byte");
    wr(4'h9, 32'hFFFF_FFFF);
    rd(4'h9, 32'h0, "R2 unmapped reads zero");
    rd(A_CH, 32'hF5, "R2 unmapped write ignored");

    // R3 write of output swing, R5/R6 busy profile
    wr(A_CH, 32'h0);
    wr(A_OFS, 32'h0);
    wr(A_DATA, 32'h28);
    wr(A_CTRL, 32'h1);
    for (int k = 0; k < BUSY; k++) rd(A_CTRL, ST_BUSY, "R5 R6 busy during access");
    rd(A_CTRL, 32'h0, "R5 busy drops after BUSY_CYC");
    wr(A_DATA, 32'h0);
    fetch(0, 0, 8'h28, "R3 swing slot written");

    // R4 data register loads only at completion
    store(2, 1, 8'h33);
    wr(A_DATA, 32'h77);
    wr(A_CTRL, 32'h2);
    rd(A_DATA, 32'h77, "R4 data unchanged while busy");
    idle(BUSY - 1);
    rd(A_DATA, 32'h33, "R4 data loaded at completion");

    // R7 / R11 command while busy, selector changes during busy
    wr(A_CH, 32'h1);
    wr(A_OFS, 32'h2);
    wr(A_DATA, 32'h44);
    wr(A_CTRL, 32'h1);
    wr(A_CH, 32'h3);
    wr(A_DATA, 32'h99);
    wr(A_CTRL, 32'h2);
    idle(BUSY);
    rd(A_CTRL, ST_ERR, "R7 rejected command sets error");
    rd(A_DATA, 32'h99, "R7 rejected read did not load");
    rd(A_CH, 32'h3, "R11 register write during busy kept");

    // R9 sticky error and write-one-to-clear
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, ST_ERR, "R9 error holds on zero write");
    wr(A_CTRL, ST_ERR);
    rd(A_CTRL, 32'h0, "R9 error cleared by write one");
    fetch(1, 2, 8'h44, "R11 access used captured selectors");
    fetch(3, 2, 8'h00, "R11 later channel not written");

    // R9 set wins over clear
    store(0, 3, 8'h11);
    wr(A_CTRL, 32'h1);
    wr(A_CTRL, 32'h201);
    idle(BUSY);
    rd(A_CTRL, ST_ERR, "R9 fault wins over clear");
    wr(A_CTRL, ST_ERR);
    fetch(0, 3, 8'h11, "R7 in-flight write completed");

    // R8 out-of-range channel and offset
    wr(A_CH, 32'h4);
    wr(A_OFS, 32'h0);
    wr(A_DATA, 32'hEE);
    wr(A_CTRL, 32'h1);
    rd(A_CTRL, ST_ERR, "R8 bad channel: error, no busy");
    wr(A_CTRL, ST_ERR);
    fetch(0, 0, 8'h28, "R8 table untouched by bad channel");
    wr(A_OFS, 32'h4);
    wr(A_CTRL, 32'h2);
    rd(A_CTRL, ST_ERR, "R8 bad offset: error, no busy");
    idle(BUSY);
    rd(A_DATA, 32'h28, "R8 data untouched by bad offset");
    wr(A_CTRL, ST_ERR);

    // R10 both command bits: write wins; offset 1 is pre-tap
    wr(A_CH, 32'h0);
    wr(A_OFS, 32'h1);
    wr(A_DATA, 32'h05);
    wr(A_CTRL, 32'h3);
    idle(BUSY);
    rd(A_DATA, 32'h05, "R10 data not reloaded");
    wr(A_DATA, 32'h0);
    fetch(0, 1, 8'h05, "R10 pre-tap slot written");

    idle(3);
    if (sb_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL scoreboard leftover: actual=%0d expected=0", sb_q.size());
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule